// File: doc/BRIEF.md
# Dual-Clock Ready-Flag FIFO

This block is a one-direction buffer of 512 words of 18 bits between two free-running clocks. The clocks may be unrelated or may be the same clock. A producer on the write clock pushes words while `in_ready` is high. A consumer on the read clock takes words while `out_ready` is high. Each ready flag is generated in the domain that uses it. The pointers from the opposite domain reach it through a two-flop Gray-code synchronizer.

The read side works in first-word-fall-through style. The oldest word is moved into an output register, and `out_ready` rises in the same read cycle. A read with `rd_en` high consumes the word that is visible on `rd_data`. When the last word has been consumed, `out_ready` falls and the register keeps that word. A new word replaces it only when `out_ready` rises again.

The write domain also produces a half-full flag and an almost flag. The almost flag marks occupancy near either end, at a distance set by the static `almost_lvl` input. Occupancy counts every word that has been written and not yet consumed, including the word held in the output register.

Top module: `rdy_xclk_fifo`

## Requirements
- R1: The FIFO accepts exactly 512 words of 18 bits with no reads. Further writes while full are dropped: draining afterwards returns exactly the first 512 words.
- R2: A write takes effect on a rising `wr_clk` edge only when `wr_en` and `in_ready` are both high. `in_ready` is registered and goes low at the edge that brings occupancy to 512.
- R3: A read takes effect on a rising `rd_clk` edge only when `rd_en` and `out_ready` are both high. Words come out in the order they were written, unchanged.
- R4: When both ports share one clock, a word written at edge k into an empty FIFO appears on `rd_data` with `out_ready` high after edge k+3, and `out_ready` is still low after edge k+2.
- R5: After the last word is consumed, `out_ready` is low and `rd_data` keeps that word until `out_ready` rises again.
- R6: When both ports share one clock, a read at edge j from a full FIFO leaves `in_ready` low through edge j+2 and raises it after edge j+3.
- R7: `half_full` is a write-clock register that is high when occupancy is at least 257, and low at 256 or below.
- R8: `almost_flag` is a write-clock register that is high when occupancy is at most N or at least 512−N, where N is the value on `almost_lvl`.
- R9: While `arst_n` is low: `in_ready`=1, `out_ready`=0, `half_full`=0, `almost_flag`=1, and `rd_data`=0.
- R10: With unrelated clocks and random traffic, no word is lost, duplicated or reordered. Each pointer that crosses domains changes by at most one bit per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| arst_n | input | 1 | Asynchronous reset, active low, shared by both sides |
| wr_en | input | 1 | Write request |
| wr_data | input | 18 | Word to write |
| almost_lvl | input | 9 | Almost-flag distance N, held static |
| in_ready | output | 1 | Space available (write domain) |
| half_full | output | 1 | Occupancy at least 257 (write domain) |
| almost_flag | output | 1 | Occupancy within N of empty or full (write domain) |
| rd_en | input | 1 | Read request |
| rd_data | output | 18 | Output register holding the head word |
| out_ready | output | 1 | `rd_data` holds an unread word (read domain) |

## Verification
In the directed part, both ports run on one clock so that every latency is an exact edge count:
- `in_ready`, `half_full` and `almost_flag` respond to a write at the same edge.
- A first word falls through three read edges after it is written.
- Freed space reaches `in_ready` three write edges after a read.

Inputs change only on falling edges, and each check samples on the falling edge that follows the edge at which the result is due. In the random part the clocks are unrelated, so the checks do not count cycles. Each consumed word is compared with a model queue. Model entries are added when a write is accepted and removed at the falling edge before a read.

// File: rtl/rdy_fifo_pkg.sv
package rdy_fifo_pkg;

  // Binary to Gray on a wide container; callers truncate to their pointer width.
  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  // Gray to binary as a prefix XOR built by doubling shifts.
  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b = g;
    b = b ^ (b >> 1);
    b = b ^ (b >> 2);
    b = b ^ (b >> 4);
    b = b ^ (b >> 8);
    b = b ^ (b >> 16);
    return b;
  endfunction

  // Words held between two pointers of width pw (modulo 2**pw).
  function automatic logic [31:0] fill_level(input logic [31:0] wp,
                                             input logic [31:0] rp,
                                             input int unsigned pw);
    return (wp - rp) & ((32'd1 << pw) - 32'd1);
  endfunction

  function automatic logic is_half(input logic [31:0] occ, input logic [31:0] depth);
    return occ > (depth >> 1);
  endfunction

  function automatic logic is_almost(input logic [31:0] occ, input logic [31:0] n,
                                     input logic [31:0] depth);
    return (occ <= n) || ((occ + n) >= depth);
  endfunction

endpackage

// File: rtl/rdy_sync2.sv
module rdy_sync2 #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/rdy_ram.sv
module rdy_ram #(
  parameter int AW = 9,
  parameter int DW = 18
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/rdy_wr_ctl.sv
module rdy_wr_ctl
  import rdy_fifo_pkg::*;
#(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          wr_en,
  input  logic [AW:0]   cgray_s,
  input  logic [AW-1:0] almost_lvl,
  output logic          wr_fire,
  output logic [AW-1:0] wr_addr,
  output logic [AW:0]   wgray,
  output logic          in_ready,
  output logic          half_full,
  output logic          almost_flag
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] FULL_LVL = PW'(1) << AW;

  logic [PW-1:0] wptr_q, wptr_nx, cptr_b, occ_now, occ_nx;

  assign wr_fire = wr_en & in_ready;
  assign cptr_b  = PW'(gray2bin(32'(cgray_s)));
  assign wptr_nx = wptr_q + PW'(wr_fire);
  assign occ_now = PW'(fill_level(32'(wptr_q), 32'(cptr_b), PW));
  assign occ_nx  = PW'(fill_level(32'(wptr_nx), 32'(cptr_b), PW));
  assign wr_addr = wptr_q[AW-1:0];

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      wptr_q      <= '0;
      wgray       <= '0;
      in_ready    <= 1'b1;
      half_full   <= 1'b0;
      almost_flag <= 1'b1;
    end else begin
      wptr_q      <= wptr_nx;
      wgray       <= PW'(bin2gray(32'(wptr_nx)));
      in_ready    <= (occ_nx != FULL_LVL);
      half_full   <= is_half(32'(occ_nx), 32'(FULL_LVL));
      almost_flag <= is_almost(32'(occ_nx), 32'(almost_lvl), 32'(FULL_LVL));
    end
  end

  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!arst_n)
    occ_now <= FULL_LVL); // R1
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!arst_n)
    !in_ready |=> (wptr_q == $past(wptr_q))); // R2
  AST_FULL_IMPLIES_HALF: assert property (@(posedge clk) disable iff (!arst_n)
    !in_ready |-> half_full); // R7
  AST_WGRAY_STEP: assert property (@(posedge clk) disable iff (!arst_n)
    $countones(wgray ^ $past(wgray)) <= 1); // R10
endmodule

// File: rtl/rdy_rd_ctl.sv
module rdy_rd_ctl
  import rdy_fifo_pkg::*;
#(
  parameter int AW = 9,
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          rd_en,
  input  logic [AW:0]   wgray_s,
  input  logic [DW-1:0] mem_q,
  output logic [AW-1:0] rd_addr,
  output logic [AW:0]   cgray,
  output logic [DW-1:0] rd_data,
  output logic          out_ready
);
  localparam int PW = AW + 1;

  logic [PW-1:0] rptr_q, cptr_q, cptr_nx;
  logic          mem_avail, rd_pop, rd_load;

  assign mem_avail = (PW'(bin2gray(32'(rptr_q))) != wgray_s);
  assign rd_pop    = rd_en & out_ready;
  assign rd_load   = mem_avail & (rd_pop | ~out_ready);
  assign cptr_nx   = cptr_q + PW'(rd_pop);
  assign rd_addr   = rptr_q[AW-1:0];

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rptr_q    <= '0;
      cptr_q    <= '0;
      cgray     <= '0;
      rd_data   <= '0;
      out_ready <= 1'b0;
    end else begin
      rptr_q    <= rptr_q + PW'(rd_load);
      cptr_q    <= cptr_nx;
      cgray     <= PW'(bin2gray(32'(cptr_nx)));
      out_ready <= rd_load | (out_ready & ~rd_pop);
      if (rd_load) rd_data <= mem_q;
    end
  end

  AST_ORDY_MATCHES: assert property (@(posedge clk) disable iff (!arst_n)
    out_ready == (rptr_q != cptr_q)); // R3
  AST_HOLD_LAST: assert property (@(posedge clk) disable iff (!arst_n)
    !out_ready |=> (out_ready || $stable(rd_data))); // R5
  AST_CGRAY_STEP: assert property (@(posedge clk) disable iff (!arst_n)
    $countones(cgray ^ $past(cgray)) <= 1); // R10
endmodule

// File: rtl/rdy_xclk_fifo.sv
module rdy_xclk_fifo #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 18
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              arst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] almost_lvl,
  output logic              in_ready,
  output logic              half_full,
  output logic              almost_flag,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              out_ready
);
  localparam int PW = ADDR_W + 1;

  logic              wr_fire;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [PW-1:0]     wgray, wgray_s, cgray, cgray_s;
  logic [DATA_W-1:0] mem_q;

  rdy_wr_ctl #(.AW(ADDR_W)) u_wr (
    .clk(wr_clk), .arst_n(arst_n), .wr_en(wr_en), .cgray_s(cgray_s),
    .almost_lvl(almost_lvl), .wr_fire(wr_fire), .wr_addr(wr_addr),
    .wgray(wgray), .in_ready(in_ready), .half_full(half_full),
    .almost_flag(almost_flag)
  );

  rdy_sync2 #(.W(PW)) u_sync_w2r (
    .clk(rd_clk), .arst_n(arst_n), .d(wgray), .q(wgray_s)
  );

  rdy_sync2 #(.W(PW)) u_sync_r2w (
    .clk(wr_clk), .arst_n(arst_n), .d(cgray), .q(cgray_s)
  );

  rdy_ram #(.AW(ADDR_W), .DW(DATA_W)) u_ram (
    .wclk(wr_clk), .we(wr_fire), .waddr(wr_addr), .wdata(wr_data),
    .raddr(rd_addr), .rdata(mem_q)
  );

  rdy_rd_ctl #(.AW(ADDR_W), .DW(DATA_W)) u_rd (
    .clk(rd_clk), .arst_n(arst_n), .rd_en(rd_en), .wgray_s(wgray_s),
    .mem_q(mem_q), .rd_addr(rd_addr), .cgray(cgray), .rd_data(rd_data),
    .out_ready(out_ready)
  );
endmodule

// File: tb/rdy_xclk_fifo_tb.sv
`timescale 1ns/1ps
module rdy_xclk_fifo_tb_top;
  localparam int DEPTH = 512;

  logic        wr_clk = 1'b0, alt_clk = 1'b0, same_clk = 1'b1;
  logic        rd_clk;
  logic        arst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [17:0] wr_data = '0;
  logic [8:0]  almost_lvl = 9'd8;
  logic        in_ready, half_full, almost_flag, out_ready;
  logic [17:0] rd_data;

  int nchk = 0, nfail = 0;
  logic [17:0] model_q[$];
  bit wr_done = 1'b0;

  always #2.5 wr_clk = ~wr_clk;
  always #3.5 alt_clk = ~alt_clk;
  assign rd_clk = same_clk ? wr_clk : alt_clk;

  rdy_xclk_fifo dut_i (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .arst_n(arst_n), .wr_en(wr_en),
    .wr_data(wr_data), .almost_lvl(almost_lvl), .in_ready(in_ready),
    .half_full(half_full), .almost_flag(almost_flag), .rd_en(rd_en),
    .rd_data(rd_data), .out_ready(out_ready)
  );

  function automatic logic [17:0] val(input int i);
    return 18'(i * 7919 + 3);
  endfunction
  function automatic bit exp_half(input int occ);
    return occ >= DEPTH / 2 + 1;
  endfunction
  function automatic bit exp_almost(input int occ, input int n);
    return (occ <= n) || (occ >= DEPTH - n);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic we, input logic [17:0] d, input logic re);
    wr_en = we; wr_data = d; rd_en = re;
    @(negedge wr_clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic do_reset(input logic same, input logic [8:0] n);
    arst_n = 1'b0;
    same_clk = same;
    almost_lvl = n;
    repeat (3) @(negedge wr_clk);
    arst_n = 1'b1;
    @(negedge wr_clk);
  endtask

  initial begin
    #1000000;
    nchk++; nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    logic [17:0] d0;
    void'($urandom(32'd4242));
    // R9 reset values, sampled while reset is held
    arst_n = 1'b0;
    repeat (2) @(negedge wr_clk);
    check(in_ready == 1 && out_ready == 0 && half_full == 0 && almost_flag == 1 && rd_data == 0,
          "R9", {in_ready, out_ready, half_full, almost_flag}, 4'b1001);
    do_reset(1'b1, 9'd8);

    // R4 fall-through latency
    d0 = 18'h25a5a;
    cyc(1'b1, d0, 1'b0);
    cyc(1'b0, '0, 1'b0);
    cyc(1'b0, '0, 1'b0);
    check(out_ready == 0, "R4 early", out_ready, 0);
    cyc(1'b0, '0, 1'b0);
    check(out_ready == 1 && rd_data == d0, "R4", rd_data, d0);

    // R5 last word held after it is consumed
    cyc(1'b0, '0, 1'b1);
    check(out_ready == 0 && rd_data == d0, "R5", rd_data, d0);
    repeat (5) cyc(1'b0, '0, 1'b0);
    check(out_ready == 0 && rd_data == d0, "R5 hold", rd_data, d0);

    // Fill: R2, R7, R8
    for (int i = 0; i < DEPTH; i++) begin
      cyc(1'b1, val(i), 1'b0);
      if (i == 7 || i == 8 || i == 502 || i == 503)
        check(almost_flag == exp_almost(i + 1, 8), "R8", almost_flag, exp_almost(i + 1, 8));
      if (i == 255 || i == 256)
        check(half_full == exp_half(i + 1), "R7", half_full, exp_half(i + 1));
      if (i == 510 || i == 511)
        check(in_ready == (i != 511), "R2", in_ready, (i != 511));
    end
    for (int i = 0; i < 3; i++) cyc(1'b1, 18'h3ffff, 1'b0);
    check(in_ready == 0 && half_full == 1, "R2 full", {in_ready, half_full}, 2'b01);

    // R6 space recovery latency
    check(out_ready == 1 && rd_data == val(0), "R3 head", rd_data, val(0));
    cyc(1'b0, '0, 1'b1);
    cyc(1'b0, '0, 1'b0);
    cyc(1'b0, '0, 1'b0);
    check(in_ready == 0, "R6 early", in_ready, 0);
    cyc(1'b0, '0, 1'b0);
    check(in_ready == 1, "R6", in_ready, 1);

    // R1 / R3 drain returns exactly the first 512 words in order
    for (int k = 1; k < DEPTH; k++) begin
      check(out_ready == 1 && rd_data == val(k), "R1 R3 order", rd_data, val(k));
      cyc(1'b0, '0, 1'b1);
    end
    repeat (6) cyc(1'b0, '0, 1'b0);
    check(out_ready == 0 && rd_data == val(DEPTH - 1), "R1 no extra", {out_ready, rd_data},
          {1'b0, val(DEPTH - 1)});

    // R8 with another threshold
    do_reset(1'b1, 9'd3);
    for (int i = 0; i < 4; i++) begin
      cyc(1'b1, val(i), 1'b0);
      if (i >= 2)
        check(almost_flag == exp_almost(i + 1, 3), "R8 n3", almost_flag, exp_almost(i + 1, 3));
    end

    // R10 random traffic on unrelated clocks
    do_reset(1'b0, 9'd8);
    fork
      begin
        for (int c = 0; c < 6000; c++) begin
          @(negedge wr_clk);
          wr_en = ($urandom % 100) < (((c / 700) % 2) ? 25 : 85);
          wr_data = 18'($urandom);
          if (wr_en && in_ready) model_q.push_back(wr_data);
        end
        @(negedge wr_clk);
        wr_en = 1'b0;
        wr_done = 1'b1;
      end
      begin
        int rc = 0;
        while (!(wr_done && model_q.size() == 0)) begin
          @(negedge rd_clk);
          rc++;
          rd_en = ($urandom % 100) < (((rc / 500) % 2) ? 90 : 30);
          if (rd_en && out_ready) begin
            if (model_q.size() == 0) check(1'b0, "R10 spurious", rd_data, 0);
            else begin
              logic [17:0] e;
              e = model_q.pop_front();
              check(rd_data == e, "R10", rd_data, e);
            end
          end
        end
        @(negedge rd_clk);
        rd_en = 1'b0;
      end
    join
    repeat (10) @(negedge rd_clk);
    check(out_ready == 0, "R10 drained", out_ready, 0);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule